// File: doc/BRIEF.md
# Memory bit test-and-modify unit

This block executes three single-bit memory operations: test a bit, test a bit and clear it, and test a bit and set it. The sequencer hands it an opcode word that has already been fetched, a second word that describes the operand, and an extension word that is used only by indexed addressing. The unit forms a word address. It reads the named workspace register through a read port, or uses the workspace pointer when the operand is the register word itself.

The unit then reads the target word over a request/acknowledge memory port. It copies the chosen bit into the equal status flag. For the clear and set variants it writes the word back, with that one bit forced, as the second half of a single read-modify-write sequence. Bits are numbered from the most significant end, so the bit displacement counts down from the MSB.

Top module: `bit_test_modify`

## Requirements
- R1: Opcode 0x0C09 selects test-only, 0x0C0A selects test-and-clear and 0x0C0B selects test-and-set.
- R2: In the descriptor word, bits [9:6] hold the bit displacement, bits [5:4] the addressing mode and bits [3:0] the register number. Displacement d selects mask 0x8000 >> d, so d = 6 selects 0x0200.
- R3: Each mode yields its own address. Mode 00 gives wsPtr + 2·reg. Mode 01 gives the register contents. Mode 10 gives the extension word plus the register contents. Mode 11 behaves as mode 01. Bit 0 of the address is always driven 0.
- R4: eqFlag takes the value the selected bit had when read, before any change. It is updated in the cycle after the read acknowledge and at no other time.
- R5: Test-only performs exactly one read and no write, and memory keeps its contents.
- R6: Test-and-clear writes back the read word with the selected bit at 0 and every other bit unchanged.
- R7: Test-and-set writes back the read word with the selected bit at 1 and every other bit unchanged. It writes even when the bit was already 1.
- R8: While memReq is high and memAck has not been seen, memReq, memWe, memAddr and memWdata hold steady.
- R9: busy rises the cycle after an accepted start and stays high through the cycle in which done is high. done lasts exactly one cycle. A start raised while busy is high is ignored.
- R10: Any other opcode raises illegal for exactly one cycle, in the cycle after start. It leaves busy low, makes no memory request and does not change eqFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing the supplied words |
| opWord | input | 16 | Opcode word |
| descWord | input | 16 | Operand descriptor word |
| extWord | input | 16 | Address extension word (indexed mode only) |
| wsPtr | input | 16 | Workspace pointer (byte address of register 0) |
| regIdx | output | 4 | Workspace register read index |
| regData | input | 16 | Contents of the register at regIdx |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Word address in bytes, bit 0 zero |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |
| eqFlag | output | 1 | Equal status flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
Two things can fall in the same clock edge: capturing the read value into eqFlag, and launching the write-back request that carries the modified word. Both happen when the read acknowledge is taken. The bench provokes this with zero-wait acknowledges, which put the write request in the very next cycle, and repeats it with one- and two-cycle waits. Each run is judged by comparing eqFlag with the bit in the preloaded word, and the final memory word and write count with values worked out from the mask. A second overlap is a new start arriving while an operation is still waiting on memory. The bench checks that this start is dropped: there is one write and one done pulse.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam int WORD_W = 16;
  localparam int DISP_W = 4;
  localparam int MODE_W = 2;
  localparam int RIDX_W = 4;
  localparam int DESC_USED_W = DISP_W + MODE_W + RIDX_W;

  localparam logic [WORD_W-1:0] OPC_TEST = 16'h0C09;
  localparam logic [WORD_W-1:0] OPC_CLR  = 16'h0C0A;
  localparam logic [WORD_W-1:0] OPC_SET  = 16'h0C0B;

  typedef enum logic [1:0] {OP_TEST, OP_CLR, OP_SET, OP_BAD} opKind_t;
  typedef enum logic [1:0] {AM_REG = 2'b00, AM_IND = 2'b01, AM_IDX = 2'b10, AM_INDX = 2'b11} addrMode_t;

  typedef struct packed {
    logic loadInsn;
    logic loadAddr;
    logic captureRead;
  } dpStrobe_t;

  function automatic opKind_t decodeOp(input logic [WORD_W-1:0] w);
    case (w)
      OPC_TEST: decodeOp = OP_TEST;
      OPC_CLR:  decodeOp = OP_CLR;
      OPC_SET:  decodeOp = OP_SET;
      default:  decodeOp = OP_BAD;
    endcase
  endfunction
endpackage

// File: rtl/btm_datapath.sv
module btm_datapath
  import btm_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strb,
  input  logic [W-1:0]    opWord,
  input  logic [W-1:0]    descWord,
  input  logic [W-1:0]    extWord,
  input  logic [W-1:0]    wsPtr,
  input  logic [W-1:0]    regData,
  input  logic [W-1:0]    memRdata,
  output logic [RIDX_W-1:0] regIdx,
  output opKind_t         opKindNow,
  output opKind_t         opKindQ,
  output logic [W-1:0]    memAddr,
  output logic [W-1:0]    memWdata,
  output logic            eqFlag
);
  localparam int MODE_LSB = RIDX_W;
  localparam int DISP_LSB = RIDX_W + MODE_W;

  logic [DESC_USED_W-1:0] descQ;
  logic [W-1:0] extQ, addrQ, dataQ, eaRaw, bitMask;
  logic [DISP_W-1:0] dispQ;
  addrMode_t modeQ;
  logic eqQ;

  assign dispQ  = descQ[DISP_LSB +: DISP_W];
  assign modeQ  = addrMode_t'(descQ[MODE_LSB +: MODE_W]);
  assign regIdx = descQ[0 +: RIDX_W];
  assign opKindNow = decodeOp(opWord);

  // MSB-first bit numbering: displacement 0 picks the top bit
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign bitMask[W-1-i] = (dispQ == DISP_W'(i));
  end

  always_comb begin
    case (modeQ)
      AM_REG:  eaRaw = wsPtr + {{(W-RIDX_W-1){1'b0}}, regIdx, 1'b0};
      AM_IDX:  eaRaw = extQ + regData;
      default: eaRaw = regData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descQ   <= '0;
      extQ    <= '0;
      opKindQ <= OP_TEST;
      addrQ   <= '0;
      dataQ   <= '0;
      eqQ     <= 1'b0;
    end else begin
      if (strb.loadInsn) begin
        descQ   <= descWord[DESC_USED_W-1:0];
        extQ    <= extWord;
        opKindQ <= opKindNow;
      end
      if (strb.loadAddr) addrQ <= {eaRaw[W-1:1], 1'b0};
      if (strb.captureRead) begin
        eqQ   <= |(memRdata & bitMask);
        dataQ <= (opKindQ == OP_CLR) ? (memRdata & ~bitMask) : (memRdata | bitMask);
      end
    end
  end

  assign memAddr  = addrQ;
  assign memWdata = dataQ;
  assign eqFlag   = eqQ;

  a_r3_addr_even: assert property (@(posedge clk) disable iff (!rstN) memAddr[0] == 1'b0);
endmodule

// File: rtl/btm_ctrl.sv
module btm_ctrl
  import btm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  opKind_t   opKindNow,
  input  opKind_t   opKindQ,
  input  logic      memAck,
  output dpStrobe_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      busy,
  output logic      done,
  output logic      illegal
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_READ, S_WRITE, S_DONE} state_t;
  state_t state, stateNext;
  logic illegalQ;

  always_comb begin
    stateNext = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      S_IDLE: if (start && opKindNow != OP_BAD) begin
        strb.loadInsn = 1'b1;
        stateNext     = S_ADDR;
      end
      S_ADDR: begin
        strb.loadAddr = 1'b1;
        stateNext     = S_READ;
      end
      S_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.captureRead = 1'b1;
          stateNext = (opKindQ == OP_TEST) ? S_DONE : S_WRITE;
        end
      end
      S_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) stateNext = S_DONE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      illegalQ <= 1'b0;
    end else begin
      state    <= stateNext;
      illegalQ <= (state == S_IDLE) && start && (opKindNow == OP_BAD);
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);
  assign illegal = illegalQ;

  a_r9_done_single:   assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  a_r9_busy_to_done:  assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> $past(done));
  a_r5_test_no_write: assert property (@(posedge clk) disable iff (!rstN) memWe |-> (opKindQ != OP_TEST));
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN) illegal |-> (!busy && !memReq));
endmodule

// File: rtl/bit_test_modify.sv
module bit_test_modify
  import btm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] opWord,
  input  logic [WORD_W-1:0] descWord,
  input  logic [WORD_W-1:0] extWord,
  input  logic [WORD_W-1:0] wsPtr,
  output logic [RIDX_W-1:0] regIdx,
  input  logic [WORD_W-1:0] regData,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck,
  output logic              eqFlag,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  dpStrobe_t strb;
  opKind_t   opKindNow, opKindQ;

  btm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opKindNow(opKindNow), .opKindQ(opKindQ),
    .memAck(memAck), .strb(strb), .memReq(memReq), .memWe(memWe),
    .busy(busy), .done(done), .illegal(illegal)
  );

  btm_datapath #(.W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opWord(opWord), .descWord(descWord),
    .extWord(extWord), .wsPtr(wsPtr), .regData(regData), .memRdata(memRdata),
    .regIdx(regIdx), .opKindNow(opKindNow), .opKindQ(opKindQ),
    .memAddr(memAddr), .memWdata(memWdata), .eqFlag(eqFlag)
  );

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));
  a_r4_eq_after_read: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(eqFlag) |-> $past(memReq && memAck && !memWe));
endmodule

// File: tb/bit_test_modify_bench.sv
module bit_test_modify_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] opWord = '0, descWord = '0, extWord = '0;
  logic [15:0] wsPtr = 16'h0040;
  logic [3:0]  regIdx;
  logic [15:0] regData;
  logic memReq, memWe, memAck = 1'b0;
  logic [15:0] memAddr, memWdata, memRdata = '0;
  logic eqFlag, busy, done, illegal;

  always #4 clk = ~clk;

  bit_test_modify u_bit_test_modify (
    .clk(clk), .rstN(rstN), .start(start), .opWord(opWord), .descWord(descWord),
    .extWord(extWord), .wsPtr(wsPtr), .regIdx(regIdx), .regData(regData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .eqFlag(eqFlag), .busy(busy),
    .done(done), .illegal(illegal)
  );

  logic [15:0] wsRegs [0:15];
  assign regData = wsRegs[regIdx];

  logic [15:0] mem [0:255];
  int ackDelay = 0;
  int waitCnt = 0;
  int writeCount = 0, accessCount = 0, doneCount = 0, stabErrs = 0;
  logic [15:0] lastAddr = '0, holdAddr = '0, holdWdata = '0;
  logic holdWe = 1'b0;

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (done) doneCount <= doneCount + 1;
    if (memReq && !memAck) begin
      if (waitCnt == 0) begin
        holdAddr <= memAddr; holdWe <= memWe; holdWdata <= memWdata;
      end else if (memAddr != holdAddr || memWe != holdWe || memWdata != holdWdata) begin
        stabErrs <= stabErrs + 1;
      end
      if (waitCnt >= ackDelay) begin
        memAck      <= 1'b1;
        waitCnt     <= 0;
        lastAddr    <= memAddr;
        accessCount <= accessCount + 1;
        memRdata    <= mem[memAddr[8:1]];
        if (memWe) begin
          mem[memAddr[8:1]] <= memWdata;
          writeCount <= writeCount + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] op;
    logic [15:0] desc;
    logic [15:0] ext;
    logic [15:0] addr;
    logic [15:0] init;
    logic        expEq;
    logic [15:0] fin;
    logic        expWr;
  } vec_t;

  // desc = disp<<6 | mode<<4 | reg ; mask = 0x8000 >> disp
  localparam vec_t VECS [8] = '{
    '{16'h0C0A, 16'h01A3, 16'h0100, 16'h0100, 16'h0200, 1'b1, 16'h0000, 1'b1},
    '{16'h0C0B, 16'h01A3, 16'h0100, 16'h0100, 16'h0000, 1'b0, 16'h0200, 1'b1},
    '{16'h0C09, 16'h01A3, 16'h0100, 16'h0100, 16'h0200, 1'b1, 16'h0200, 1'b0},
    '{16'h0C09, 16'h0015, 16'h0000, 16'h0010, 16'h8000, 1'b1, 16'h8000, 1'b0},
    '{16'h0C0B, 16'h03C2, 16'h0000, 16'h0044, 16'h1234, 1'b0, 16'h1235, 1'b1},
    '{16'h0C0A, 16'h03F7, 16'h0000, 16'h0120, 16'hFFFF, 1'b1, 16'hFFFE, 1'b1},
    '{16'h0C0B, 16'h00E5, 16'h0030, 16'h0040, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
    '{16'h0C0A, 16'h00E5, 16'h0030, 16'h0040, 16'h0000, 1'b0, 16'h0000, 1'b1}
  };

  task automatic issue(input logic [15:0] op, input logic [15:0] desc, input logic [15:0] ext);
    @(negedge clk);
    opWord = op; descWord = desc; extWord = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 200 && !seen; n++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int w0, a0, d0;
    for (int i = 0; i < 16; i++) wsRegs[i] = 16'h0A0A;
    wsRegs[3] = 16'h0000;
    wsRegs[5] = 16'h0010;
    wsRegs[7] = 16'h0121;
    for (int i = 0; i < 256; i++) mem[i] = 16'h5A5A;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !memReq && !eqFlag, "R9 reset",
        {busy, done, illegal, memReq, eqFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      vec_t v = VECS[i];
      ackDelay = i % 3;
      mem[v.addr[8:1]] = v.init;
      w0 = writeCount; a0 = accessCount;
      issue(v.op, v.desc, v.ext);
      chk(busy, "R9 busy after start", busy, 1);
      waitDone(seen);
      chk(seen, "R9 done seen", seen, 1);
      chk(eqFlag == v.expEq, "R4 eq flag", eqFlag, v.expEq);
      chk(lastAddr == v.addr, "R3 address", lastAddr, v.addr);
      chk(mem[v.addr[8:1]] == v.fin,
          v.op == 16'h0C09 ? "R5 test-only" : (v.op == 16'h0C0A ? "R6 clear" : "R7 set"),
          mem[v.addr[8:1]], v.fin);
      chk((writeCount - w0) == int'(v.expWr), "R1 R2 write count", writeCount - w0, v.expWr);
      chk((accessCount - a0) == 1 + int'(v.expWr), "R5 access count", accessCount - a0, 1 + v.expWr);
      @(negedge clk);
      chk(!done && !busy, "R9 done single", {done, busy}, 0);
    end

    // R10: unknown opcode with eqFlag known (last vector left it 0; force 1 first)
    ackDelay = 0;
    mem[8'h80] = 16'h0200;
    issue(16'h0C09, 16'h01A3, 16'h0100);
    waitDone(seen);
    @(negedge clk);
    a0 = accessCount;
    issue(16'h0C08, 16'h01A3, 16'h0100);
    chk(illegal && !busy, "R10 illegal pulse", {illegal, busy}, 2'b10);
    @(negedge clk);
    chk(!illegal && !busy, "R10 illegal one cycle", {illegal, busy}, 0);
    repeat (3) @(negedge clk);
    chk(accessCount == a0, "R10 no access", accessCount, a0);
    chk(eqFlag == 1'b1, "R10 eq kept", eqFlag, 1);

    // R9: start while busy is dropped
    ackDelay = 4;
    mem[8'h80] = 16'h0000;
    w0 = writeCount; d0 = doneCount;
    issue(16'h0C0B, 16'h01A3, 16'h0100);
    @(negedge clk);
    issue(16'h0C0A, 16'h01A3, 16'h0100);
    waitDone(seen);
    repeat (4) @(negedge clk);
    chk(mem[8'h80] == 16'h0200, "R9 second start ignored", mem[8'h80], 16'h0200);
    chk(writeCount - w0 == 1, "R9 one write", writeCount - w0, 1);
    chk(doneCount - d0 == 1, "R9 one done", doneCount - d0, 1);
    chk(stabErrs == 0, "R8 request held", stabErrs, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule